// File: doc/BRIEF.md
# Segmented Converter Input Decoder

This block is the digital front end of a 10-bit current-steering converter. Each rising edge of the sample clock captures a 10-bit input word and a quadrature-mode control. From these it produces two sets of drive lines. Six binary-weighted lines go to a resistor ladder. Fifteen unary enables go to equal-weight segment current cells. The enables come from thermometer-coding the top four bits of the word.

When quadrature mode is set, the nine low bits of the word are complemented and the top bit is passed through unchanged. The top bit then works as a sign. A sine generator can then store only a quarter wave and use this control to flip the output.

The converter takes a new sample on every edge. It cannot stall, so there is no valid/ready handshake and no back-pressure. Every output comes straight from a flip-flop, which gives one cycle of latency.

Top module: `seg_dac_decoder`

## Requirements
- R1: A clock edge with `rst_n` low sets every bit of `bin_drv` and `seg_en` to 0 (synchronous, active-low reset).
- R2: With `quad_inv` = 0, the effective code equals `code_in` unchanged.
- R3: With `quad_inv` = 1, the effective code has bits 0 to 8 of `code_in` complemented and bit 9 kept as is.
- R4: `bin_drv[i]` equals bit i of the effective code, for i from 0 to 5 (bit 0 is the LSB).
- R5: For N equal to bits 9..6 of the effective code, `seg_en[0]` to `seg_en[N-1]` are 1 and all other enables are 0. The enables are contiguous from index 0, and exactly N of them are set.
- R6: The outputs show the code and the mode sampled on the previous rising edge. `quad_inv` is sampled on the same edge as the data it applies to.
- R7: 64 times the number of set enables, plus the value of `bin_drv`, equals the effective 10-bit code.
- R8: `seg_en[7]` equals bit 9 of the sampled `code_in` in both modes, so the sign is never inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 10 | Input sample word, bit 0 is the LSB |
| quad_inv | input | 1 | Quadrature mode: complement bits 0 to 8 when set |
| bin_drv | output | 6 | Binary-weighted ladder drive lines |
| seg_en | output | 15 | Unary segment current-cell enables |

## Verification
Every result is due exactly one rising edge after its stimulus. The bench drives the word and the mode on a falling edge. It then waits for the next rising edge and samples 1 ns later, well before the following falling edge changes the inputs. The expected values come from integer arithmetic on the same inputs. The checks cover all 1024 codes in each mode, a mid-stream reset asserted with a nonzero code, and mode toggles on back-to-back samples. Each cycle checks the exact bit pattern, the enable count, the contiguity of the enables, the reconstructed code and the sign enable.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  parameter int DAC_LSB_W = 6;
  parameter int DAC_MSB_W = 4;
  parameter int DAC_WORD_W = DAC_LSB_W + DAC_MSB_W;
  parameter int DAC_SEG_N = (1 << DAC_MSB_W) - 1;
endpackage

// File: rtl/dac_mode_xform.sv
module dac_mode_xform #(
  parameter int WORD_W = dac_front_pkg::DAC_WORD_W
) (
  input  logic [WORD_W-1:0] raw_i,
  input  logic              inv_i,
  output logic [WORD_W-1:0] eff_o
);
  // the sign bit is never complemented
  assign eff_o[WORD_W-1] = raw_i[WORD_W-1];

  for (genvar b = 0; b < WORD_W - 1; b++) begin : g_mag
    assign eff_o[b] = raw_i[b] ^ inv_i;
  end

  // R3
  always_comb begin
    sign_kept_chk: assert (eff_o[WORD_W-1] == raw_i[WORD_W-1]);
  end
endmodule

// File: rtl/dac_therm_enc.sv
module dac_therm_enc #(
  parameter int MSB_W = dac_front_pkg::DAC_MSB_W,
  localparam int SEG_N = (1 << MSB_W) - 1
) (
  input  logic [MSB_W-1:0] n_i,
  output logic [SEG_N-1:0] en_o
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    localparam logic [MSB_W-1:0] IDX = i[MSB_W-1:0];
    assign en_o[i] = (n_i > IDX);
  end

  // R5
  always_comb begin
    therm_count_chk: assert ($countones(en_o) == int'(n_i));
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int LSB_W = dac_front_pkg::DAC_LSB_W,
  parameter int MSB_W = dac_front_pkg::DAC_MSB_W,
  localparam int WORD_W = LSB_W + MSB_W,
  localparam int SEG_N = (1 << MSB_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] code_in,
  input  logic              quad_inv,
  output logic [LSB_W-1:0]  bin_drv,
  output logic [SEG_N-1:0]  seg_en
);
  logic [WORD_W-1:0] eff_code;
  logic [SEG_N-1:0]  seg_next;

  dac_mode_xform #(.WORD_W(WORD_W)) u_xform (
    .raw_i(code_in),
    .inv_i(quad_inv),
    .eff_o(eff_code)
  );

  dac_therm_enc #(.MSB_W(MSB_W)) u_therm (
    .n_i (eff_code[WORD_W-1:LSB_W]),
    .en_o(seg_next)
  );

  // data and mode share one sampling edge; outputs are pure flop state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_drv <= '0;
      seg_en  <= '0;
    end else begin
      bin_drv <= eff_code[LSB_W-1:0];
      seg_en  <= seg_next;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (bin_drv == '0 && seg_en == '0));

  // R5
  seg_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_en & (seg_en + 1'b1)) == '0));

  // R6
  bin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (bin_drv == ($past(code_in[LSB_W-1:0]) ^ {LSB_W{$past(quad_inv)}})));

  // R8
  sign_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (seg_en[SEG_N/2] == $past(code_in[WORD_W-1])));
endmodule

// File: tb/seg_dac_decoder_test.sv
module seg_dac_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  code_in = '0;
  logic        quad_inv = 1'b0;
  logic [5:0]  bin_drv;
  logic [14:0] seg_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_dac_decoder uut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .quad_inv(quad_inv),
    .bin_drv(bin_drv), .seg_en(seg_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one sample, wait for its capture edge, then check against the model
  task automatic step(input int c, input bit inv, input bit rst);
    int eff, upper, lower, exp_seg, ones, contig, first_zero;
    @(negedge clk);
    code_in  = c[9:0];
    quad_inv = inv;
    rst_n    = ~rst;
    @(posedge clk);
    #1;
    if (rst) begin
      chk("R1 bin", int'(bin_drv), 0);
      chk("R1 seg", int'(seg_en), 0);
    end else begin
      eff = inv ? (c ^ 511) : c;                 // R2 / R3
      upper = eff / 64;
      lower = eff % 64;
      exp_seg = (1 << upper) - 1;
      chk(inv ? "R3 R4 R6 bin" : "R2 R4 R6 bin", int'(bin_drv), lower);
      chk("R5 R6 seg", int'(seg_en), exp_seg);
      ones = 0; contig = 1; first_zero = 0;
      for (int i = 0; i < 15; i++) begin
        if (seg_en[i]) begin
          ones++;
          if (first_zero != 0) contig = 0;
        end else first_zero = 1;
      end
      chk("R5 count", ones, upper);
      chk("R5 contig", contig, 1);
      chk("R7 sum", 64 * ones + int'(bin_drv), eff);
      chk("R8 sign", int'(seg_en[7]), (c >> 9) & 1);
    end
  endtask

  initial begin
    step(0, 1'b0, 1'b1);
    step(1023, 1'b1, 1'b1);
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 1024; c++) step(c, m[0], 1'b0);
    end
    step(700, 1'b1, 1'b1);                      // R1 mid-stream reset
    step(700, 1'b1, 1'b0);
    for (int k = 0; k < 64; k++) step((k * 97) % 1024, k[0], 1'b0);  // R6 toggles
    step(0, 1'b1, 1'b0);
    step(512, 1'b1, 1'b0);
    step(511, 1'b0, 1'b0);
    step(1023, 1'b0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule